// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative table. Each table slot describes two neighbouring 4 KB virtual pages: one even and one odd. Each half has its own frame number, its own valid bit and its own dirty (write-enable) bit. Every slot is compared against the request in parallel. A slot matches when its stored tag is equal to the request's tag and one more condition holds: the slot is marked global, or its stored address-space ID is equal to the current one.

Before the table is consulted, a segment check runs on the request. A user-mode access to the upper half of the address space is refused with a dedicated code. A lower-half access while the error-level flag is set is not mapped and passes through unchanged. All other accesses are translated by the table. The result comes back one cycle after the request. It carries a physical address, a read-permission bit, a write-permission bit and a 3-bit result code, so the caller can tell each kind of failure apart.

A one-cycle entry write port loads a complete slot. Refill, victim choice and exception raising are the caller's job.

Top module: `pair_tlb`

## Requirements
- R1: A slot hits when its tag equals request address bits [31:13] and either its global bit is set or its stored ID equals `cur_asid`; a non-global slot with a different ID does not hit.
- R2: Address bit 12 selects the odd (1) or even (0) half of the hitting slot; on success `rsp_pa` is the selected frame number in bits [31:12] with request bits [11:0] below it.
- R3: If the selected half's valid bit is clear, the code is 3 (invalid), and `rsp_pa`, `rsp_rd_ok` and `rsp_wr_ok` are 0.
- R4: A write whose selected half has its dirty bit clear gives code 4 (dirty violation) with no permissions; a read of the same half succeeds.
- R5: On success (code 0) `rsp_rd_ok` is 1 and `rsp_wr_ok` equals the selected dirty bit; on any failure both are 0.
- R6: In user mode any address with bit 31 set gives code 1 (bad address), whatever the table holds.
- R7: An address with bit 31 clear while `req_erl` is 1 is unmapped: code 0, `rsp_pa` equal to the address, both permissions 1.
- R8: A translated address that hits no slot gives code 2 (no match).
- R9: When several slots hit, the lowest-index slot supplies the result.
- R10: `rsp_vld` is 1 exactly one cycle after `req_vld`; the other outputs change only on a response and hold their values otherwise.
- R11: `wr_en` loads all fields of slot `wr_idx` in one cycle; a lookup in the same cycle sees the slot's previous contents, and the next lookup sees the new ones.
- R12: In privileged mode an address with bit 31 set is translated through the table, whatever the value of `req_erl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode |
| req_erl | input | 1 | Error-level flag |
| cur_asid | input | 8 | Current address-space ID |
| rsp_vld | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_code | output | 3 | 0 match, 1 bad address, 2 no match, 3 invalid, 4 dirty |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_tag | input | 19 | Tag (address bits [31:13]) |
| wr_asid | input | 8 | Stored address-space ID |
| wr_glob | input | 1 | Global bit |
| wr_pfn_even | input | 20 | Even-half frame number |
| wr_v_even | input | 1 | Even-half valid |
| wr_d_even | input | 1 | Even-half dirty |
| wr_pfn_odd | input | 20 | Odd-half frame number |
| wr_v_odd | input | 1 | Odd-half valid |
| wr_d_odd | input | 1 | Odd-half dirty |

## Verification
A lookup and a slot write can land on the same clock edge. The hazard arises when the write targets the very slot the lookup will hit. The bench provokes this by raising `req_vld` and `wr_en` together, with the write giving a resident slot a new frame number. It expects the response to carry the old frame. A second lookup on the next cycle must then return the new frame.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

   typedef enum logic [2:0] {
      XL_OK      = 3'd0,
      XL_BADADDR = 3'd1,
      XL_MISS    = 3'd2,
      XL_INVALID = 3'd3,
      XL_DIRTY   = 3'd4
   } xl_code_e;

endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store #(
   parameter int N     = 16,
   parameter int TAG_W = 19,
   parameter int ID_W  = 8,
   parameter int PFN_W = 20,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [ID_W-1:0]  wr_id,
   input  logic             wr_glob,
   input  logic [PFN_W-1:0] wr_pfn_e,
   input  logic             wr_v_e,
   input  logic             wr_d_e,
   input  logic [PFN_W-1:0] wr_pfn_o,
   input  logic             wr_v_o,
   input  logic             wr_d_o,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [ID_W-1:0]  lk_id,
   output logic [N-1:0]     hit_vec,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             rd_odd,
   output logic [PFN_W-1:0] rd_pfn,
   output logic             rd_v,
   output logic             rd_d
);

   logic [TAG_W-1:0] tag_q   [N];
   logic [ID_W-1:0]  id_q    [N];
   logic             glob_q  [N];
   logic [PFN_W-1:0] pfn_e_q [N];
   logic [PFN_W-1:0] pfn_o_q [N];
   logic             v_e_q   [N];
   logic             v_o_q   [N];
   logic             d_e_q   [N];
   logic             d_o_q   [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            tag_q[i]   <= '0;
            id_q[i]    <= '0;
            glob_q[i]  <= 1'b0;
            pfn_e_q[i] <= '0;
            pfn_o_q[i] <= '0;
            v_e_q[i]   <= 1'b0;
            v_o_q[i]   <= 1'b0;
            d_e_q[i]   <= 1'b0;
            d_o_q[i]   <= 1'b0;
         end
      end else if (wr_en) begin
         tag_q[wr_idx]   <= wr_tag;
         id_q[wr_idx]    <= wr_id;
         glob_q[wr_idx]  <= wr_glob;
         pfn_e_q[wr_idx] <= wr_pfn_e;
         pfn_o_q[wr_idx] <= wr_pfn_o;
         v_e_q[wr_idx]   <= wr_v_e;
         v_o_q[wr_idx]   <= wr_v_o;
         d_e_q[wr_idx]   <= wr_d_e;
         d_o_q[wr_idx]   <= wr_d_o;
      end
   end

   // parallel compare, one comparator pair per slot
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = (tag_q[g] == lk_tag) &&
                          (glob_q[g] || (id_q[g] == lk_id));
   end

   // half select of the granted slot
   always_comb begin
      rd_pfn = rd_odd ? pfn_o_q[rd_idx] : pfn_e_q[rd_idx];
      rd_v   = rd_odd ? v_o_q[rd_idx]   : v_e_q[rd_idx];
      rd_d   = rd_odd ? d_o_q[rd_idx]   : d_e_q[rd_idx];
   end

   // R11
   slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_tag)) &&
                (pfn_o_q[$past(wr_idx)] == $past(wr_pfn_o)));

endmodule

// File: rtl/pair_tlb_prio.sv
module pair_tlb_prio #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

   // R9
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[idx] &&
              ((req & ((N'(1) << idx) - N'(1))) == '0));

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
   import pair_tlb_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ID_W      = 8,
   localparam int TAG_W    = VA_W - PAGE_BITS - 1,
   localparam int PFN_W    = VA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_wr,
   input  logic             req_user,
   input  logic             req_erl,
   input  logic [ID_W-1:0]  cur_asid,
   output logic             rsp_vld,
   output logic [VA_W-1:0]  rsp_pa,
   output logic             rsp_rd_ok,
   output logic             rsp_wr_ok,
   output logic [2:0]       rsp_code,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [ID_W-1:0]  wr_asid,
   input  logic             wr_glob,
   input  logic [PFN_W-1:0] wr_pfn_even,
   input  logic             wr_v_even,
   input  logic             wr_d_even,
   input  logic [PFN_W-1:0] wr_pfn_odd,
   input  logic             wr_v_odd,
   input  logic             wr_d_odd
);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("pair_tlb: ENTRIES must be a power of two and at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS > VA_W - 2) begin : g_bad_page
      $error("pair_tlb: PAGE_BITS out of range for VA_W");
   end

   logic [TAG_W-1:0] lk_tag;
   logic             lk_odd;
   logic             upper;
   logic [ENTRIES-1:0] hit_vec;
   logic [IDX_W-1:0] hit_idx;
   logic             hit_any;
   logic [PFN_W-1:0] sel_pfn;
   logic             sel_v;
   logic             sel_d;

   assign lk_tag = req_va[VA_W-1 -: TAG_W];
   assign lk_odd = req_va[PAGE_BITS];
   assign upper  = req_va[VA_W-1];

   pair_tlb_store #(
      .N(ENTRIES), .TAG_W(TAG_W), .ID_W(ID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_id    (wr_asid),
      .wr_glob  (wr_glob),
      .wr_pfn_e (wr_pfn_even),
      .wr_v_e   (wr_v_even),
      .wr_d_e   (wr_d_even),
      .wr_pfn_o (wr_pfn_odd),
      .wr_v_o   (wr_v_odd),
      .wr_d_o   (wr_d_odd),
      .lk_tag   (lk_tag),
      .lk_id    (cur_asid),
      .hit_vec  (hit_vec),
      .rd_idx   (hit_idx),
      .rd_odd   (lk_odd),
      .rd_pfn   (sel_pfn),
      .rd_v     (sel_v),
      .rd_d     (sel_d)
   );

   pair_tlb_prio #(
      .N(ENTRIES), .IDX_W(IDX_W)
   ) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (hit_vec),
      .idx   (hit_idx),
      .any   (hit_any)
   );

   xl_code_e         nx_code;
   logic [VA_W-1:0]  nx_pa;
   logic             nx_rd;
   logic             nx_wr;

   // segment gate, then table result resolution
   always_comb begin
      nx_code = XL_OK;
      nx_pa   = '0;
      nx_rd   = 1'b0;
      nx_wr   = 1'b0;
      if (req_user && upper) begin
         nx_code = XL_BADADDR;
      end else if (!upper && req_erl) begin
         nx_pa = req_va;
         nx_rd = 1'b1;
         nx_wr = 1'b1;
      end else if (!hit_any) begin
         nx_code = XL_MISS;
      end else if (!sel_v) begin
         nx_code = XL_INVALID;
      end else if (req_wr && !sel_d) begin
         nx_code = XL_DIRTY;
      end else begin
         nx_pa = {sel_pfn, req_va[PAGE_BITS-1:0]};
         nx_rd = 1'b1;
         nx_wr = sel_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_pa    <= '0;
         rsp_rd_ok <= 1'b0;
         rsp_wr_ok <= 1'b0;
         rsp_code  <= 3'd0;
      end else begin
         rsp_vld <= req_vld;
         if (req_vld) begin
            rsp_pa    <= nx_pa;
            rsp_rd_ok <= nx_rd;
            rsp_wr_ok <= nx_wr;
            rsp_code  <= nx_code;
         end
      end
   end

   // R10
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   // R10
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld && $stable(rsp_pa) && $stable(rsp_code));

   // R6
   user_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_user && req_va[VA_W-1]) |=> rsp_code == XL_BADADDR);

   // R2
   pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (rsp_code != XL_OK) ||
                  (rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0])));

   // R5
   fail_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code != XL_OK) |-> !rsp_rd_ok && !rsp_wr_ok);

   // R5
   ok_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_code == XL_OK) |-> rsp_rd_ok);

   // R4
   write_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr) |=> (rsp_code != XL_OK) || rsp_wr_ok);

endmodule

// File: tb/pair_tlb_tb.sv
`timescale 1ns/1ps
module pair_tlb_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_wr = 1'b0;
   logic        req_user = 1'b0;
   logic        req_erl = 1'b0;
   logic [7:0]  cur_asid = '0;
   logic        rsp_vld;
   logic [31:0] rsp_pa;
   logic        rsp_rd_ok;
   logic        rsp_wr_ok;
   logic [2:0]  rsp_code;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [18:0] wr_tag = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_glob = 1'b0;
   logic [19:0] wr_pfn_even = '0;
   logic        wr_v_even = 1'b0;
   logic        wr_d_even = 1'b0;
   logic [19:0] wr_pfn_odd = '0;
   logic        wr_v_odd = 1'b0;
   logic        wr_d_odd = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [2:0] C_OK = 3'd0, C_BAD = 3'd1, C_MISS = 3'd2,
                          C_INV = 3'd3, C_DIRTY = 3'd4;

   always #2.5 clk = ~clk;

   pair_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_va(req_va),
      .req_wr(req_wr), .req_user(req_user), .req_erl(req_erl),
      .cur_asid(cur_asid), .rsp_vld(rsp_vld), .rsp_pa(rsp_pa),
      .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_code(rsp_code),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_asid(wr_asid),
      .wr_glob(wr_glob), .wr_pfn_even(wr_pfn_even), .wr_v_even(wr_v_even),
      .wr_d_even(wr_d_even), .wr_pfn_odd(wr_pfn_odd), .wr_v_odd(wr_v_odd),
      .wr_d_odd(wr_d_odd)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_slot(input logic [3:0] idx, input logic [18:0] tag,
                           input logic [7:0] id, input logic g,
                           input logic [19:0] pe, input logic ve, input logic de,
                           input logic [19:0] po, input logic vo, input logic d_o);
      wr_idx = idx; wr_tag = tag; wr_asid = id; wr_glob = g;
      wr_pfn_even = pe; wr_v_even = ve; wr_d_even = de;
      wr_pfn_odd = po; wr_v_odd = vo; wr_d_odd = d_o;
   endtask

   task automatic load(input logic [3:0] idx, input logic [18:0] tag,
                       input logic [7:0] id, input logic g,
                       input logic [19:0] pe, input logic ve, input logic de,
                       input logic [19:0] po, input logic vo, input logic d_o);
      @(negedge clk);
      set_slot(idx, tag, id, g, pe, ve, de, po, vo, d_o);
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input string req, input logic [31:0] va, input logic wr,
                       input logic user, input logic erl, input logic [7:0] id,
                       input logic [2:0] e_code, input logic [31:0] e_pa,
                       input logic e_rd, input logic e_wr);
      @(negedge clk);
      req_va = va; req_wr = wr; req_user = user; req_erl = erl;
      cur_asid = id; req_vld = 1'b1;
      @(negedge clk);
      req_vld = 1'b0;
      check({req, " vld"}, 64'(rsp_vld), 64'd1);
      check({req, " code"}, 64'(rsp_code), 64'(e_code));
      check({req, " pa"}, 64'(rsp_pa), 64'(e_pa));
      check({req, " rd"}, 64'(rsp_rd_ok), 64'(e_rd));
      check({req, " wr"}, 64'(rsp_wr_ok), 64'(e_wr));
   endtask

   localparam logic [18:0] T1 = 19'h01234;
   localparam logic [18:0] T2 = 19'h00777;
   localparam logic [18:0] T3 = 19'h00042;
   localparam logic [18:0] T4 = 19'h60000;

   task automatic t_reset();
      check("R10 reset vld", 64'(rsp_vld), 64'd0);
      check("R10 reset code", 64'(rsp_code), 64'd0);
      check("R10 reset pa", 64'(rsp_pa), 64'd0);
   endtask

   task automatic t_basic();
      load(4'd3, T1, 8'h55, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 20'h0BEEF, 1'b1, 1'b0);
      look("R2 even read", {T1, 1'b0, 12'h345}, 0, 0, 0, 8'h55, C_OK, 32'hAAAAA345, 1, 1);
      look("R5 odd read", {T1, 1'b1, 12'hABC}, 0, 0, 0, 8'h55, C_OK, 32'h0BEEFABC, 1, 0);
      look("R4 odd write", {T1, 1'b1, 12'hABC}, 1, 0, 0, 8'h55, C_DIRTY, 32'h0, 0, 0);
      look("R5 even write", {T1, 1'b0, 12'h001}, 1, 0, 0, 8'h55, C_OK, 32'hAAAAA001, 1, 1);
      look("R1 id mismatch", {T1, 1'b0, 12'h345}, 0, 0, 0, 8'h56, C_MISS, 32'h0, 0, 0);
      look("R8 no slot", {19'h05555, 1'b0, 12'h010}, 0, 0, 0, 8'h55, C_MISS, 32'h0, 0, 0);
   endtask

   task automatic t_global();
      load(4'd5, T2, 8'h11, 1'b1, 20'h00000, 1'b0, 1'b0, 20'h12345, 1'b1, 1'b1);
      look("R1 global odd", {T2, 1'b1, 12'h777}, 0, 0, 0, 8'h99, C_OK, 32'h12345777, 1, 1);
      look("R3 invalid even", {T2, 1'b0, 12'h777}, 0, 0, 0, 8'h99, C_INV, 32'h0, 0, 0);
   endtask

   task automatic t_prio();
      load(4'd9, T3, 8'h00, 1'b1, 20'h00999, 1'b1, 1'b1, 20'h00999, 1'b1, 1'b1);
      load(4'd2, T3, 8'h00, 1'b1, 20'h00222, 1'b1, 1'b1, 20'h00222, 1'b1, 1'b1);
      look("R9 lowest wins", {T3, 1'b0, 12'h00F}, 0, 0, 0, 8'h33, C_OK, 32'h0022200F, 1, 1);
   endtask

   task automatic t_segment();
      load(4'd7, T4, 8'h00, 1'b1, 20'h0CAFE, 1'b1, 1'b1, 20'h0CAFE, 1'b1, 1'b1);
      look("R6 user upper", {T4, 1'b0, 12'h123}, 0, 1, 0, 8'h00, C_BAD, 32'h0, 0, 0);
      look("R12 kernel upper", {T4, 1'b0, 12'h123}, 0, 0, 0, 8'h00, C_OK, 32'h0CAFE123, 1, 1);
      look("R12 kernel upper erl", {T4, 1'b0, 12'h456}, 0, 0, 1, 8'h00, C_OK, 32'h0CAFE456, 1, 1);
      look("R7 erl unmapped", 32'h00001234, 1, 0, 1, 8'h00, C_OK, 32'h00001234, 1, 1);
      look("R7 erl over slot", {T1, 1'b1, 12'hABC}, 1, 0, 1, 8'h55, C_OK, {T1, 1'b1, 12'hABC}, 1, 1);
   endtask

   task automatic t_collide();
      @(negedge clk);
      set_slot(4'd3, T1, 8'h55, 1'b0, 20'h0F00D, 1'b1, 1'b1, 20'h0BEEF, 1'b1, 1'b0);
      wr_en = 1'b1;
      req_va = {T1, 1'b0, 12'h020}; req_wr = 0; req_user = 0; req_erl = 0;
      cur_asid = 8'h55; req_vld = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; req_vld = 1'b0;
      check("R11 same cycle old", 64'(rsp_pa), 64'h00000000AAAAA020);
      look("R11 next new", {T1, 1'b0, 12'h020}, 0, 0, 0, 8'h55, C_OK, 32'h0F00D020, 1, 1);
   endtask

   task automatic t_hold();
      logic [31:0] pa_prev;
      look("R10 response", {T2, 1'b1, 12'h001}, 0, 0, 0, 8'h01, C_OK, 32'h12345001, 1, 1);
      pa_prev = rsp_pa;
      @(negedge clk);
      req_va = 32'hFFFF_FFFF;
      check("R10 idle vld", 64'(rsp_vld), 64'd0);
      check("R10 idle hold", 64'(rsp_pa), 64'(pa_prev));
      @(negedge clk);
      check("R10 idle hold 2", 64'(rsp_code), 64'(C_OK));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_basic();
      t_global();
      t_prio();
      t_segment();
      t_collide();
      t_hold();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule